// File: doc/BRIEF.md
# Branch Squash Controller for a Five-Stage Pipeline

This block steers the front of a five-stage in-order pipeline (fetch, decode, execute, memory, write-back) and removes wrong-path work after control transfers. Each instruction moves through the stage registers as a token. The token holds a valid flag, its PC, a kind code, a branch target and an opaque tag. Fetch normally steps the PC by four bytes.

An unconditional jump is detected while it sits in decode. A conditional branch is settled in execute by the `ex_taken` input. When either one redirects fetch, the younger tokens lose their valid flag but keep moving down as bubbles. A bubble never raises the memory-stage or write-back enables.

The instruction source is a combinational lookup. The block presents `if_pc`, and the environment answers in the same cycle with the kind, target and tag of the word at that address. The retire side (`wb_valid`, `wb_pc`, `wb_tag`) is a valid-only stream with no ready input. The pipeline never stalls, so a consumer must take every token in the cycle it is shown. The memory enable is a plain control pin.

Top module: `squash_pipe_ctrl`

## Requirements
- R1: While `rst` is high at a clock edge, the next cycle shows `if_pc` = 0 with `wb_valid` and `mem_valid` low.
- R2: In a cycle with no redirect, the next `if_pc` is the current `if_pc` plus 4. After reset is released, the word at PC 0 retires on the 4th rising edge. Non-branch words retire on consecutive cycles.
- R3: A valid token of kind 2'b01 (jump) in decode redirects fetch to its target and kills the one token fetched behind it. The next architectural instruction therefore retires 2 cycles after the jump.
- R4: A valid token of kind 2'b10 (conditional branch) in execute, with `ex_taken` = 1, redirects fetch to its target and kills the two tokens in decode and fetch. The next instruction retires 3 cycles after the branch.
- R5: A conditional branch with `ex_taken` = 0 causes no redirect and no bubble. Kind codes 2'b00 and 2'b11 are plain operations, and `ex_taken` has no effect on them.
- R6: Killed tokens never raise `mem_valid` or `wb_valid`. The retired PCs follow architectural program order, and each `wb_tag` equals the tag supplied when that PC was fetched.
- R7: When an execute-stage redirect and a decode-stage redirect occur in the same cycle, fetch goes to the execute-stage target.
- R8: A killed jump or killed conditional branch never redirects fetch.
- R9: A token that shows `mem_valid` in one cycle shows `wb_valid` in the next cycle with the same PC. No `wb_valid` appears without `mem_valid` in the cycle before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| if_pc | output | 16 | Fetch address |
| if_kind | input | 2 | Kind of the word at `if_pc`: 00 op, 01 jump, 10 conditional branch, 11 op |
| if_target | input | 16 | Branch target of the word at `if_pc` |
| if_tag | input | 8 | Opaque payload of the word at `if_pc` |
| ex_taken | input | 1 | Outcome of the conditional branch in execute |
| mem_valid | output | 1 | Memory stage holds a live token (side-effect enable) |
| wb_valid | output | 1 | Write-back holds a live token (register write enable) |
| wb_pc | output | 16 | PC of the retiring token |
| wb_tag | output | 8 | Tag of the retiring token |

## Verification
A single program runs twice, once with every conditional branch not taken and once with every one taken. The two runs distinguish the sequential path, the one-bubble jump path and the two-bubble branch path. Both the retired PC and the gap in cycles before each retirement are compared against an architectural model. The program deliberately places a jump directly behind a conditional branch, so that only the execute-stage priority yields the right target. It also places a jump and a conditional branch in slots that must be squashed; if either fired, fetch would go to a different target. A short run that is cut by a mid-run reset shows that reset kills tokens already in flight.

// File: rtl/squash_pipe_pkg.sv
package squash_pipe_pkg;
  parameter int unsigned PC_W       = 16;
  parameter int unsigned TAG_W      = 8;
  parameter int unsigned INSN_BYTES = 4;
  parameter int unsigned N_STAGES   = 5;

  typedef enum logic [1:0] {
    K_OP   = 2'b00,
    K_JUMP = 2'b01,
    K_COND = 2'b10,
    K_OP2  = 2'b11
  } kind_e;

  typedef struct packed {
    logic             valid;
    logic [PC_W-1:0]  pc;
    kind_e            kind;
    logic [PC_W-1:0]  target;
    logic [TAG_W-1:0] tag;
  } token_t;
endpackage

// File: rtl/squash_stage_reg.sv
module squash_stage_reg
  import squash_pipe_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   kill,
  input  token_t d,
  output token_t q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      q <= '0;
    end else begin
      q       <= d;
      q.valid <= d.valid & ~kill;
    end
  end
endmodule

// File: rtl/squash_redirect.sv
module squash_redirect
  import squash_pipe_pkg::*;
(
  input  token_t          id_tok,
  input  token_t          ex_tok,
  input  logic            ex_taken,
  output logic            ex_redir,
  output logic            id_redir,
  output logic            any_redir,
  output logic [PC_W-1:0] redir_pc
);
  always_comb begin
    ex_redir  = ex_tok.valid && (ex_tok.kind == K_COND) && ex_taken;
    id_redir  = id_tok.valid && (id_tok.kind == K_JUMP);
    any_redir = ex_redir || id_redir;
    // the older token wins
    redir_pc  = ex_redir ? ex_tok.target : id_tok.target;
  end
endmodule

// File: rtl/squash_pc_gen.sv
module squash_pc_gen
  import squash_pipe_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            redir,
  input  logic [PC_W-1:0] redir_pc,
  output logic [PC_W-1:0] pc
);
  localparam logic [PC_W-1:0] STEP = PC_W'(INSN_BYTES);

  always_ff @(posedge clk) begin
    if (rst)        pc <= '0;
    else if (redir) pc <= redir_pc;
    else            pc <= pc + STEP;
  end
endmodule

// File: rtl/squash_pipe_ctrl.sv
module squash_pipe_ctrl
  import squash_pipe_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  output logic [PC_W-1:0]  if_pc,
  input  logic [1:0]       if_kind,
  input  logic [PC_W-1:0]  if_target,
  input  logic [TAG_W-1:0] if_tag,
  input  logic             ex_taken,
  output logic             mem_valid,
  output logic             wb_valid,
  output logic [PC_W-1:0]  wb_pc,
  output logic [TAG_W-1:0] wb_tag
);
  localparam int unsigned S_IF  = 0;
  localparam int unsigned S_ID  = 1;
  localparam int unsigned S_EX  = 2;
  localparam int unsigned S_MEM = 3;
  localparam int unsigned S_WB  = N_STAGES - 1;

  token_t [N_STAGES-1:0] stg;
  logic   [N_STAGES-1:0] kill;
  logic                  ex_redir, id_redir, any_redir;
  logic   [PC_W-1:0]     redir_pc;

  // probes for the bound checker
  logic                  id_vld, ex_vld;
  logic   [PC_W-1:0]     id_tgt, ex_tgt, mem_pc;

  squash_pc_gen u_pc (
    .clk(clk), .rst(rst), .redir(any_redir), .redir_pc(redir_pc), .pc(if_pc)
  );

  always_comb begin
    stg[S_IF].valid  = 1'b1;
    stg[S_IF].pc     = if_pc;
    stg[S_IF].kind   = kind_e'(if_kind);
    stg[S_IF].target = if_target;
    stg[S_IF].tag    = if_tag;
  end

  squash_redirect u_redir (
    .id_tok(stg[S_ID]), .ex_tok(stg[S_EX]), .ex_taken(ex_taken),
    .ex_redir(ex_redir), .id_redir(id_redir), .any_redir(any_redir),
    .redir_pc(redir_pc)
  );

  // kill[i] clears the valid flag of the token entering stage i
  always_comb begin
    kill        = '0;
    kill[S_ID]  = any_redir;
    kill[S_EX]  = ex_redir;
  end

  for (genvar i = 1; i < N_STAGES; i++) begin : g_stage
    squash_stage_reg u_reg (
      .clk(clk), .rst(rst), .kill(kill[i]), .d(stg[i-1]), .q(stg[i])
    );
  end

  assign mem_valid = stg[S_MEM].valid;
  assign wb_valid  = stg[S_WB].valid;
  assign wb_pc     = stg[S_WB].pc;
  assign wb_tag    = stg[S_WB].tag;

  assign id_vld = stg[S_ID].valid;
  assign ex_vld = stg[S_EX].valid;
  assign id_tgt = stg[S_ID].target;
  assign ex_tgt = stg[S_EX].target;
  assign mem_pc = stg[S_MEM].pc;
endmodule

// File: rtl/squash_pipe_chk.sv
module squash_pipe_chk
  import squash_pipe_pkg::*;
(
  input logic            clk,
  input logic            rst,
  input logic [PC_W-1:0] if_pc,
  input logic            mem_valid,
  input logic            wb_valid,
  input logic [PC_W-1:0] wb_pc,
  input logic            ex_redir,
  input logic            id_redir,
  input logic            id_vld,
  input logic            ex_vld,
  input logic [PC_W-1:0] id_tgt,
  input logic [PC_W-1:0] ex_tgt,
  input logic [PC_W-1:0] mem_pc
);
  localparam logic [PC_W-1:0] STEP = PC_W'(INSN_BYTES);

  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> (if_pc == '0) && !wb_valid && !mem_valid); // R1

  AST_SEQ_FETCH: assert property (@(posedge clk) disable iff (rst)
    (!ex_redir && !id_redir) |=> (if_pc == $past(if_pc) + STEP)); // R2

  AST_JUMP_TARGET: assert property (@(posedge clk) disable iff (rst)
    (id_redir && !ex_redir) |=> (if_pc == $past(id_tgt))); // R3

  AST_JUMP_KILLS_ONE: assert property (@(posedge clk) disable iff (rst)
    id_redir |=> !id_vld); // R3

  AST_COND_KILLS_TWO: assert property (@(posedge clk) disable iff (rst)
    ex_redir |=> (!id_vld && !ex_vld)); // R4

  AST_EX_PRIORITY: assert property (@(posedge clk) disable iff (rst)
    ex_redir |=> (if_pc == $past(ex_tgt))); // R7

  AST_MEM_TO_WB: assert property (@(posedge clk) disable iff (rst)
    mem_valid |=> (wb_valid && (wb_pc == $past(mem_pc)))); // R9

  AST_NO_WB_WITHOUT_MEM: assert property (@(posedge clk) disable iff (rst)
    !mem_valid |=> !wb_valid); // R9
endmodule

bind squash_pipe_ctrl squash_pipe_chk u_chk (
  .clk(clk), .rst(rst), .if_pc(if_pc), .mem_valid(mem_valid),
  .wb_valid(wb_valid), .wb_pc(wb_pc), .ex_redir(ex_redir),
  .id_redir(id_redir), .id_vld(id_vld), .ex_vld(ex_vld),
  .id_tgt(id_tgt), .ex_tgt(ex_tgt), .mem_pc(mem_pc)
);

// File: tb/test_squash_pipe_ctrl.sv
module test_squash_pipe_ctrl;
  import squash_pipe_pkg::*;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic [PC_W-1:0]  if_pc;
  logic [1:0]       if_kind;
  logic [PC_W-1:0]  if_target;
  logic [TAG_W-1:0] if_tag;
  logic             ex_taken = 1'b0;
  logic             mem_valid, wb_valid;
  logic [PC_W-1:0]  wb_pc;
  logic [TAG_W-1:0] wb_tag;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #4ns clk = ~clk;

  // program word: {kind[1:0], target word index[3:0]}
  localparam logic [5:0] PROG [0:15] = '{
    {2'b00, 4'd0},  {2'b01, 4'd5},  {2'b01, 4'd10}, {2'b00, 4'd0},
    {2'b00, 4'd0},  {2'b10, 4'd8},  {2'b00, 4'd0},  {2'b01, 4'd9},
    {2'b10, 4'd12}, {2'b01, 4'd14}, {2'b10, 4'd11}, {2'b00, 4'd0},
    {2'b11, 4'd0},  {2'b01, 4'd0},  {2'b00, 4'd0},  {2'b01, 4'd0}
  };

  // scenario vectors: {taken, retirements to check}
  localparam logic [8:0] SCN [0:1] = '{ {1'b0, 8'd24}, {1'b1, 8'd24} };

  function automatic logic [TAG_W-1:0] tag_of(input logic [PC_W-1:0] pc);
    return TAG_W'(pc >> 2) ^ 8'hA5;
  endfunction

  always_comb begin
    if_kind   = PROG[if_pc[5:2]][5:4];
    if_target = PC_W'({PROG[if_pc[5:2]][3:0], 2'b00});
    if_tag    = tag_of(if_pc);
  end

  squash_pipe_ctrl i_squash_pipe_ctrl (
    .clk(clk), .rst(rst), .if_pc(if_pc), .if_kind(if_kind),
    .if_target(if_target), .if_tag(if_tag), .ex_taken(ex_taken),
    .mem_valid(mem_valid), .wb_valid(wb_valid), .wb_pc(wb_pc), .wb_tag(wb_tag)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    repeat (3) @(negedge clk);
    check(if_pc == 0, "R1", "if_pc in reset", int'(if_pc), 0);
    check(!wb_valid && !mem_valid, "R1", "valids in reset",
          int'({mem_valid, wb_valid}), 0);
    rst = 1'b0;
  endtask

  task automatic run_scn(input bit taken, input int n);
    logic [PC_W-1:0] pc = '0;
    int gap = 4;
    ex_taken = taken;
    do_reset();
    for (int k = 0; k < n; k++) begin
      int cyc = 0;
      logic [1:0] kd;
      do begin
        @(negedge clk); cyc++;
      end while (!wb_valid && cyc < 8);
      kd = PROG[pc[5:2]][5:4];
      // R2 R3 R4 R5: bubble count before each retirement
      check(cyc == gap, (gap == 2) ? "R3" : (gap == 3) ? "R4" : "R2",
            $sformatf("gap before pc %0d", pc), cyc, gap);
      // R6 R7 R8: retirement follows architectural order
      check(wb_pc == pc, taken ? "R7" : "R8", "retired pc", int'(wb_pc), int'(pc));
      check(wb_tag == tag_of(pc), "R6", "retired tag", int'(wb_tag), int'(tag_of(pc)));
      if (kd == 2'b01) begin
        gap = 2; pc = PC_W'({PROG[pc[5:2]][3:0], 2'b00});
      end else if (kd == 2'b10 && taken) begin
        gap = 3; pc = PC_W'({PROG[pc[5:2]][3:0], 2'b00});
      end else begin
        gap = 1; pc = pc + 16'd4;   // R5 for untaken branches and ops
      end
    end
  endtask

  initial begin
    for (int s = 0; s < 2; s++) run_scn(SCN[s][8], int'(SCN[s][7:0]));

    // mid-run reset kills in-flight tokens (R1)
    ex_taken = 1'b0;
    do_reset();
    repeat (3) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check(if_pc == 0, "R1", "if_pc after mid-run reset", int'(if_pc), 0);
    check(!wb_valid && !mem_valid, "R1", "valids after mid-run reset",
          int'({mem_valid, wb_valid}), 0);
    rst = 1'b0;
    // sequential step right after release (R2)
    @(negedge clk);
    check(if_pc == 4, "R2", "first step after reset", int'(if_pc), 4);
    repeat (3) @(negedge clk);
    check(wb_valid && wb_pc == 0, "R2", "first retire on 4th edge",
          int'(wb_pc), 0);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++; failures++;
        $display("FAIL watchdog expired actual=1 expected=0");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule